// File: doc/BRIEF.md
# Masked Bit-Bang Pin Port

This block gives software direct, bit-level control over six control pins: a video encoder reset line, a clock-generator shift interface (data, shift clock and a load strobe that moves the shift register to its outputs), and the clock and data lines of two I2C buses that share a single data line. No protocol engine sits behind the pins. Software toggles them one register write at a time and reads back the levels that are actually present on the wires.

The port has two 16-bit registers on a simple bus with an address, a write strobe, write data, a read strobe and read data. One register holds the pin values and the other holds the output enables. Both use a masked write: the upper byte of the write word selects which low-byte bits take the new value, so one pin can change without a read-modify-write. Each pin is modelled as an open-drain style tri-state. A pin drives only while its enable bit is 1, and the pin output is the stored value gated by that enable. Pin levels pass through a two-stage synchroniser before they appear in the upper byte of a pin-register read.

Bit positions in the low byte: 0 is the encoder reset, 1 is the clock-generator load strobe, 2 is bus-B SCL, 3 is the shared SDA (which is also the clock-generator shift data), 4 is bus-A SCL and 5 is the clock-generator shift clock. Bits 6 and 7 have no pin.

Top module: `pin_port_regs`

## Requirements
- R1: After reset, the pin-value register reads 0x3E in its low byte. Every pin is high except bit 0, so the encoder is held in reset. The enable register reads 0x0000, and pin_oe and pin_out are all 0.
- R2: A write to the pin-value register (address 0) changes value bit n (0 to 5) only when bit n+8 of the same write word is 1. Bits whose mask bit is 0 keep their previous value.
- R3: A write of 0x0808 to the pin-value register sets only bit 3 (shared SDA) and leaves every other pin value unchanged.
- R4: The enable register (address 1) takes the same masked write. A read of it returns the stored enables in bits 0 to 5 and zeros in bits 6 to 15.
- R5: pin_oe[n] equals enable bit n. pin_out[n] equals value bit n while that pin is enabled and is 0 while it is not.
- R6: A read of the pin-value register returns the stored values in bits 0 to 5, zeros in bits 6, 7, 14 and 15, and in bits 8 to 13 the level of pin_in[0..5] after two synchroniser flops. A change on pin_in that lands before clock edge E1 is returned by a read strobe sampled at E3, not by one sampled at E1 or E2.
- R7: bus_rdata is registered. It loads the addressed word at a clock edge where bus_rd is 1, reads 0 for any unmapped address, and holds its value while bus_rd is 0.
- R8: A write to an unmapped address (2 or 3) changes neither register. Mask bits 14 and 15 and data bits 6 and 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address: 0 pin values, 1 enables |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 16 | Write word: mask in bits 15:8, values in bits 7:0 |
| bus_rd | input | 1 | Read strobe, sampled on the rising edge |
| bus_rdata | output | 16 | Registered read word |
| pin_in | input | 6 | Levels present on the pins, asynchronous |
| pin_out | output | 6 | Value driven on each pin, gated by its enable |
| pin_oe | output | 6 | Per-pin drive enable; 0 means tri-stated |

## Verification
The assertions take bus_wr, bus_rd, bus_addr and bus_wdata as synchronous to clk and settled at each rising edge. pin_in may move at any time, so the synchroniser is checked stage by stage, never end to end. The reset check assumes reset is released well before a clock edge. The bench meets these assumptions by changing every input, pin_in included, only on the falling edge, releasing reset between edges, and never issuing a strobe in the cycle that reset is released.

// File: rtl/pin_port_pkg.sv
package pin_port_pkg;

   // Low-byte position of each controlled pin
   localparam int unsigned PIN_ENC_RESET = 0;
   localparam int unsigned PIN_CG_LOAD   = 1;
   localparam int unsigned PIN_SCL_B     = 2;
   localparam int unsigned PIN_SDA       = 3;
   localparam int unsigned PIN_SCL_A     = 4;
   localparam int unsigned PIN_CG_CLK    = 5;
   localparam int unsigned PIN_NUM       = 6;

   // All lines idle high, encoder held in reset
   localparam logic [PIN_NUM-1:0] PIN_VAL_DEFAULT = 6'b111110;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_PIN  = 2'd1,
      SEL_OE   = 2'd2
   } rd_sel_e;

endpackage

// File: rtl/pin_masked_reg.sv
module pin_masked_reg #(
   parameter int unsigned FIELD_W = 8,
   parameter int unsigned WIDTH = 6,
   parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [2*FIELD_W-1:0] wdata,
   output logic [WIDTH-1:0]     q
);

   localparam int unsigned SPARE_W = FIELD_W - WIDTH;

   initial begin
      width_fit_chk: assert (WIDTH >= 1 && WIDTH <= FIELD_W)
         else $error("pin_masked_reg: WIDTH must be in 1..FIELD_W");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= RESET_VAL;
      end else if (wr_en) begin
         for (int i = 0; i < int'(WIDTH); i++) begin
            if (wdata[FIELD_W+i]) q[i] <= wdata[i];
         end
      end
   end

   // Bits above the stored width carry no state
   if (SPARE_W > 0) begin : g_spare
      logic unused_spare;
      assign unused_spare = ^{wdata[2*FIELD_W-1:FIELD_W+WIDTH], wdata[FIELD_W-1:WIDTH]};
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit_chk
      // R2
      masked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && !wdata[FIELD_W+i]) |=> $stable(q[i]));
      // R2
      masked_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && wdata[FIELD_W+i]) |=> (q[i] == $past(wdata[i])));
   end

   // R8
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(q));

   // R1
   reset_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (q == RESET_VAL));

endmodule

// File: rtl/pin_in_sync.sv
module pin_in_sync #(
   parameter int unsigned WIDTH = 6,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   logic [WIDTH-1:0] stage_q [STAGES];

   initial begin
      stage_count_chk: assert (STAGES >= 2)
         else $error("pin_in_sync: at least two stages are needed");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= '{default: '0};
      end else begin
         stage_q[0] <= din;
         for (int s = 1; s < int'(STAGES); s++) begin
            stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign dout = stage_q[STAGES-1];

   // R6
   first_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (stage_q[0] == $past(din)));

   for (genvar s = 1; s < STAGES; s++) begin : g_stage_chk
      // R6
      stage_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> (stage_q[s] == $past(stage_q[s-1])));
   end

endmodule

// File: rtl/pin_read_path.sv
module pin_read_path #(
   parameter int unsigned DATA_W = 16,
   parameter bit REGISTERED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [DATA_W-1:0] rd_word,
   output logic [DATA_W-1:0] rdata
);

   if (REGISTERED) begin : g_reg
      logic [DATA_W-1:0] rdata_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     rdata_q <= '0;
         else if (rd_en) rdata_q <= rd_word;
      end

      assign rdata = rdata_q;

      // R7
      rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !rd_en |=> $stable(rdata));
   end else begin : g_comb
      logic unused_clocking;
      assign unused_clocking = clk ^ rst_n;
      assign rdata = rd_en ? rd_word : '0;
   end

endmodule

// File: rtl/pin_port_regs.sv
module pin_port_regs
   import pin_port_pkg::*;
#(
   parameter int unsigned ADDR_W = 2,
   parameter int unsigned FIELD_W = 8,
   parameter int unsigned PIN_COUNT = PIN_NUM,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0] ADDR_PINS = 0,
   parameter logic [ADDR_W-1:0] ADDR_ENABLES = 1,
   parameter bit READ_REGISTERED = 1'b1,
   parameter logic [PIN_COUNT-1:0] VAL_RESET = PIN_VAL_DEFAULT,
   parameter logic [PIN_COUNT-1:0] OE_RESET = '0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic                 bus_wr,
   input  logic [2*FIELD_W-1:0] bus_wdata,
   input  logic                 bus_rd,
   output logic [2*FIELD_W-1:0] bus_rdata,
   input  logic [PIN_COUNT-1:0] pin_in,
   output logic [PIN_COUNT-1:0] pin_out,
   output logic [PIN_COUNT-1:0] pin_oe
);

   localparam int unsigned DATA_W = 2 * FIELD_W;

   initial begin
      pins_fit_chk: assert (PIN_COUNT >= 1 && PIN_COUNT <= FIELD_W)
         else $error("pin_port_regs: PIN_COUNT must fit in the low byte field");
      addr_distinct_chk: assert (ADDR_PINS != ADDR_ENABLES)
         else $error("pin_port_regs: register addresses must differ");
   end

   logic                 wr_pins;
   logic                 wr_enables;
   rd_sel_e              rd_sel;
   logic [PIN_COUNT-1:0] val_q;
   logic [PIN_COUNT-1:0] oe_q;
   logic [PIN_COUNT-1:0] pin_sync;
   logic [DATA_W-1:0]    rd_word;

   // Address decode
   always_comb begin
      if (bus_addr == ADDR_PINS)         rd_sel = SEL_PIN;
      else if (bus_addr == ADDR_ENABLES) rd_sel = SEL_OE;
      else                               rd_sel = SEL_NONE;
   end

   assign wr_pins    = bus_wr && (rd_sel == SEL_PIN);
   assign wr_enables = bus_wr && (rd_sel == SEL_OE);

   pin_masked_reg #(
      .FIELD_W   (FIELD_W),
      .WIDTH     (PIN_COUNT),
      .RESET_VAL (VAL_RESET)
   ) i_val_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_pins),
      .wdata (bus_wdata),
      .q     (val_q)
   );

   pin_masked_reg #(
      .FIELD_W   (FIELD_W),
      .WIDTH     (PIN_COUNT),
      .RESET_VAL (OE_RESET)
   ) i_oe_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_enables),
      .wdata (bus_wdata),
      .q     (oe_q)
   );

   pin_in_sync #(
      .WIDTH  (PIN_COUNT),
      .STAGES (SYNC_STAGES)
   ) i_in_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (pin_in),
      .dout  (pin_sync)
   );

   // Per-pin tri-state drive
   for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
      assign pin_oe[p]  = oe_q[p];
      assign pin_out[p] = oe_q[p] & val_q[p];
   end

   // Read word assembly
   always_comb begin
      rd_word = '0;
      case (rd_sel)
         SEL_PIN: begin
            rd_word[PIN_COUNT-1:0]         = val_q;
            rd_word[FIELD_W +: PIN_COUNT]  = pin_sync;
         end
         SEL_OE:  rd_word[PIN_COUNT-1:0]   = oe_q;
         default: rd_word = '0;
      endcase
   end

   pin_read_path #(
      .DATA_W     (DATA_W),
      .REGISTERED (READ_REGISTERED)
   ) i_read_path (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (bus_rd),
      .rd_word (rd_word),
      .rdata   (bus_rdata)
   );

   // R8
   unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr != ADDR_PINS && bus_addr != ADDR_ENABLES)
      |=> ($stable(pin_oe) && $stable(pin_out)));

   // R5
   drive_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_enables && !bus_wdata[FIELD_W+PIN_SDA]) |=> $stable(pin_oe[PIN_SDA]));

endmodule

// File: tb/test_pin_port_regs.sv
module test_pin_port_regs;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic        bus_rd = 1'b0;
   logic [15:0] bus_rdata;
   logic [5:0]  pin_in = '0;
   logic [5:0]  pin_out;
   logic [5:0]  pin_oe;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   pin_port_regs i_pin_port_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rd    (bus_rd),
      .bus_rdata (bus_rdata),
      .pin_in    (pin_in),
      .pin_out   (pin_out),
      .pin_oe    (pin_oe)
   );

   // {addr, write word, expected values, expected enables}
   localparam int NVEC = 12;
   localparam logic [33:0] VEC [NVEC] = '{
      {2'd0, 16'h3F00, 8'h00, 8'h00},
      {2'd0, 16'h0808, 8'h08, 8'h00},
      {2'd1, 16'h3F3F, 8'h08, 8'h3F},
      {2'd0, 16'h0137, 8'h09, 8'h3F},
      {2'd0, 16'hC0FF, 8'h09, 8'h3F},
      {2'd1, 16'h0500, 8'h09, 8'h3A},
      {2'd0, 16'h3C2A, 8'h29, 8'h3A},
      {2'd2, 16'hFFFF, 8'h29, 8'h3A},
      {2'd1, 16'h2000, 8'h29, 8'h1A},
      {2'd0, 16'h0000, 8'h29, 8'h1A},
      {2'd1, 16'hC0C0, 8'h29, 8'h1A},
      {2'd3, 16'hFFFF, 8'h29, 8'h1A}
   };

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   task automatic do_write(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic do_read(input logic [1:0] a, output logic [15:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual run still busy after 20000 cycles, expected completion");
      finish_run();
   end

   initial begin
      logic [15:0] rd;
      repeat (3) @(negedge clk);
      #5 rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 reset state
      check("R1 pin_oe", {10'd0, pin_oe}, 16'h0000);
      check("R1 pin_out", {10'd0, pin_out}, 16'h0000);
      do_read(2'd0, rd);  check("R1 value read", rd, 16'h003E);
      do_read(2'd1, rd);  check("R1 enable read", rd, 16'h0000);

      // Table walk: masked writes and readback
      for (int v = 0; v < NVEC; v++) begin
         string tag;
         logic [7:0] ev;
         logic [7:0] eo;
         ev = VEC[v][15:8];
         eo = VEC[v][7:0];
         if (v == 1) tag = "R3";
         else if (v == 4 || v == 7 || v == 9 || v == 10 || v == 11) tag = "R8";
         else tag = "R2";
         do_write(VEC[v][33:32], VEC[v][31:16]);
         do_read(2'd0, rd);  check(tag, rd, {8'h00, ev});
         do_read(2'd1, rd);  check("R4", rd, {8'h00, eo});
         check("R5 pin_oe", {10'd0, pin_oe}, {8'h00, eo});
         check("R5 pin_out", {10'd0, pin_out}, {8'h00, ev & eo});
      end

      // R6 synchroniser latency: change before E1, visible at E3
      @(negedge clk);
      pin_in = 6'h2D; bus_addr = 2'd0; bus_rd = 1'b1;
      @(negedge clk);  check("R6 read at E1", bus_rdata, 16'h0029);
      @(negedge clk);  check("R6 read at E2", bus_rdata, 16'h0029);
      @(negedge clk);  check("R6 read at E3", bus_rdata, 16'h2D29);
      bus_rd = 1'b0;

      // R4 enable read ignores pin levels
      do_read(2'd1, rd);  check("R4 upper zero", rd, 16'h001A);

      // R7 read data holds without a strobe
      do_write(2'd0, 16'h3F00);
      repeat (3) @(negedge clk);
      check("R7 hold", bus_rdata, 16'h001A);
      do_read(2'd0, rd);  check("R7 reload", rd, 16'h2D00);
      do_read(2'd2, rd);  check("R7 unmapped read", rd, 16'h0000);

      // R1 reset in mid-run
      @(negedge clk);
      pin_in = 6'h00; rst_n = 1'b0;
      repeat (2) @(negedge clk);
      #5 rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1 pin_oe again", {10'd0, pin_oe}, 16'h0000);
      check("R1 pin_out again", {10'd0, pin_out}, 16'h0000);
      do_read(2'd0, rd);  check("R1 value again", rd, 16'h003E);
      do_read(2'd1, rd);  check("R1 enable again", rd, 16'h0000);

      // R5 enable alone releases the stored value
      do_write(2'd1, 16'h0101);
      check("R5 reset pin enabled", {10'd0, pin_out}, 16'h0000);
      do_write(2'd1, 16'h0808);
      check("R5 SDA driven high", {10'd0, pin_out}, 16'h0008);

      finish_run();
   end

endmodule